// File: doc/BRIEF.md
# Scheduled Timer Event Matcher

This block turns a table of calendar timers into a stream of macro pointers. Each time a minute tick arrives while the block is idle, it records the current clock and then reads the timer table from a byte-wide memory, one entry after another. Every entry describes a window of days, a set of weekdays, a start time and a stop time. When the recorded date falls inside the window and the recorded time equals the start or stop time, the entry's matching 12-bit pointer is offered on the output port.

Each entry is 9 bytes long and the first entry sits at byte address 2. Byte k of an entry carries entry bits 71-8k down to 64-8k, so the first byte read is the most significant. A time is stored as a coarse count of 120-minute slots plus a fine offset of 0 to 119 minutes. The memory has a read latency of one cycle. The pointer output uses a valid/ready handshake, and the scan waits while the consumer is not ready. Running the macros and filling the memory belong to other blocks.

Top module: `timer_event_matcher`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `ptr_valid_o` and `mem_rd_o` are low.
- R2: A tick taken in the idle state starts a scan. The scan reads 9-byte entries starting at address 2, each at the previous entry's address plus 9. Bytes are read in address order, and the data for a read is returned one cycle after `mem_rd_o`. The first byte of an entry is entry bits 71:64 and the ninth byte is bits 7:0.
- R3: An entry whose first byte is 0xFF ends the scan. No pointer comes from that entry or from any byte stored after it.
- R4: Entry bits 70:64 form a weekday mask, with bit 64 for Sunday and bit 70 for Saturday. The weekday input is one-hot, with bit 0 for Sunday and bit 6 for Saturday. An entry can fire only if its mask shares a set bit with the weekday input.
- R5: The 9-bit first day is {bit 39, bits 63:56} and the 9-bit last day is {bit 31, bits 55:48}. An entry can fire only if first day <= day of year <= last day, with both ends inclusive. An entry whose first day is greater than its last day never fires.
- R6: The start time is bits 47:44 × 120 + bits 38:32. The current time is slot × 120 + minute. When both are equal and R4 and R5 hold, the start pointer {bits 23:20, bits 15:8} is emitted.
- R7: The stop time is bits 43:40 × 120 + bits 30:24. When it equals the current time and R4 and R5 hold, the stop pointer {bits 19:16, bits 7:0} is emitted.
- R8: Pointers leave in table order. When one entry matches both times, its start pointer is emitted before its stop pointer.
- R9: While `ptr_valid_o` is high and `ptr_ready_i` is low, `ptr_valid_o` stays high, `ptr_o` holds its value and the scan does not advance.
- R10: Ticks that arrive while a scan is in progress are ignored. Each idle tick produces exactly one scan.
- R11: The clock inputs are captured on the tick that starts a scan. Changes to them during the scan do not affect its results.
- R12: If the next entry would extend past the last memory address, the scan ends even though no terminator was found, and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle minute tick |
| now_min_i | input | 7 | Minute within the current 2-hour slot, 0..119 |
| now_slot_i | input | 4 | Current 2-hour slot of the day, 0..11 |
| now_day_i | input | 9 | Current day of year |
| now_wday_i | input | 7 | One-hot weekday, bit 0 Sunday |
| mem_addr_o | output | AW | Table memory byte address |
| mem_rd_o | output | 1 | Table memory read strobe |
| mem_data_i | input | 8 | Read data, one cycle after the strobe |
| ptr_valid_o | output | 1 | Macro pointer valid |
| ptr_ready_i | input | 1 | Consumer ready |
| ptr_o | output | 12 | Macro pointer to run |

## Verification
The bench fills the table with entries aimed at the edges of each check: days on both inclusive ends and one past them, a day above 255 that needs the split high bit, a reversed day window, and the times 0 and 1439. A design that treated the range as exclusive, dropped bit 39 or bit 31, or let a reversed window wrap around would emit too many or too few pointers. A catch-all entry placed after the terminator shows up at once if the scan runs past 0xFF. Further tests cover a back-pressured handshake, a second tick during a scan, clock inputs that change during a scan, and a table with no terminator that reaches the end of memory. These expose a design that drops or repeats a pointer, starts a second scan, reads the live clock, or wraps back to address 0 and never returns to idle.

// File: rtl/timer_event_matcher.sv
module timer_event_matcher #(
  parameter int AW         = 12,
  parameter int TABLE_BASE = 2,
  parameter int SLOT_MIN   = 120
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [6:0]    now_min_i,
  input  logic [3:0]    now_slot_i,
  input  logic [8:0]    now_day_i,
  input  logic [6:0]    now_wday_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  input  logic [7:0]    mem_data_i,
  output logic          ptr_valid_o,
  input  logic          ptr_ready_i,
  output logic [11:0]   ptr_o
);
  localparam int ENT_BYTES = 9;
  localparam int LAST_ADDR = (1 << AW) - 1;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WAIT, S_EVAL, S_OUT} state_t;

  state_t      state;
  logic [AW:0] base;
  logic [3:0]  idx;
  logic        rd_q;
  logic [71:0] ent;
  logic [6:0]  snap_min;
  logic [3:0]  snap_slot;
  logic [8:0]  snap_day;
  logic [6:0]  snap_wday;
  logic        st_pend, sp_pend;

  wire [6:0]  wmask    = ent[70:64];
  wire [8:0]  day_lo   = {ent[39], ent[63:56]};
  wire [8:0]  day_hi   = {ent[31], ent[55:48]};
  wire [10:0] start_t  = 11'(ent[47:44]) * 11'(SLOT_MIN) + 11'(ent[38:32]);
  wire [10:0] stop_t   = 11'(ent[43:40]) * 11'(SLOT_MIN) + 11'(ent[30:24]);
  wire [10:0] now_t    = 11'(snap_slot) * 11'(SLOT_MIN) + 11'(snap_min);
  wire [11:0] start_p  = {ent[23:20], ent[15:8]};
  wire [11:0] stop_p   = {ent[19:16], ent[7:0]};
  wire        is_term  = ent[71:64] == 8'hFF;
  wire        date_ok  = (|(wmask & snap_wday)) && (day_lo <= snap_day) && (snap_day <= day_hi);

  wire [AW:0] next_base = base + (AW+1)'(ENT_BYTES);
  wire        next_fits = (next_base + (AW+1)'(ENT_BYTES - 1)) <= (AW+1)'(LAST_ADDR);

  assign mem_rd_o    = state == S_RD;
  assign mem_addr_o  = base[AW-1:0] + AW'(idx);
  assign ptr_valid_o = (state == S_OUT) && (st_pend || sp_pend);
  assign ptr_o       = st_pend ? start_p : stop_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      base      <= '0;
      idx       <= '0;
      rd_q      <= 1'b0;
      ent       <= '0;
      snap_min  <= '0;
      snap_slot <= '0;
      snap_day  <= '0;
      snap_wday <= '0;
      st_pend   <= 1'b0;
      sp_pend   <= 1'b0;
    end else begin
      rd_q <= mem_rd_o;
      if (rd_q) ent <= {ent[63:0], mem_data_i};
      case (state)
        S_IDLE: if (tick_i) begin
          snap_min  <= now_min_i;
          snap_slot <= now_slot_i;
          snap_day  <= now_day_i;
          snap_wday <= now_wday_i;
          base      <= (AW+1)'(TABLE_BASE);
          idx       <= '0;
          state     <= S_RD;
        end
        S_RD: begin
          idx <= idx + 4'd1;
          if (idx == 4'(ENT_BYTES - 1)) state <= S_WAIT;
        end
        S_WAIT: state <= S_EVAL;
        S_EVAL: begin
          if (is_term) begin
            state <= S_IDLE;
          end else begin
            st_pend <= date_ok && (start_t == now_t);
            sp_pend <= date_ok && (stop_t == now_t);
            state   <= S_OUT;
          end
        end
        S_OUT: begin
          if (st_pend) begin
            if (ptr_ready_i) st_pend <= 1'b0;
          end else if (sp_pend) begin
            if (ptr_ready_i) sp_pend <= 1'b0;
          end else if (next_fits) begin
            base  <= next_base;
            idx   <= '0;
            state <= S_RD;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9
  hold_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_valid_o && !ptr_ready_i |=> ptr_valid_o && $stable(ptr_o));

  // R2
  scan_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) && tick_i |=> mem_rd_o && (mem_addr_o == AW'(TABLE_BASE)));

  // R2
  addr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> mem_addr_o >= AW'(TABLE_BASE));

  // R12
  addr_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> (base + (AW+1)'(idx)) <= (AW+1)'(LAST_ADDR));

  // R10
  no_read_on_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_valid_o |-> !mem_rd_o);
endmodule

// File: tb/timer_event_matcher_bench.sv
module timer_event_matcher_bench;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_i = 1'b0;
  logic [6:0]    now_min_i = '0;
  logic [3:0]    now_slot_i = '0;
  logic [8:0]    now_day_i = '0;
  logic [6:0]    now_wday_i = '0;
  logic [AW-1:0] mem_addr_o;
  logic          mem_rd_o;
  logic [7:0]    mem_data_i;
  logic          ptr_valid_o;
  logic          ptr_ready_i = 1'b1;
  logic [11:0]   ptr_o;

  always #2 clk = ~clk;

  timer_event_matcher #(.AW(AW)) u_timer_event_matcher (
    .clk, .rst_n, .tick_i, .now_min_i, .now_slot_i, .now_day_i, .now_wday_i,
    .mem_addr_o, .mem_rd_o, .mem_data_i, .ptr_valid_o, .ptr_ready_i, .ptr_o
  );

  logic [7:0] mem [0:255];
  always @(posedge clk) if (mem_rd_o) mem_data_i <= mem[mem_addr_o];

  int errors = 0, checks = 0;
  logic [11:0] got [0:15];
  int ngot = 0;

  always @(negedge clk) if (ptr_valid_o && ptr_ready_i) begin
    if (ngot < 16) got[ngot] = ptr_o;
    ngot++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_entry(input int slot, input logic [6:0] mask, input logic [8:0] dlo,
      input logic [8:0] dhi, input logic [3:0] sc, input logic [6:0] so,
      input logic [3:0] ec, input logic [6:0] eo, input logic [11:0] sp, input logic [11:0] ep);
    int a = 2 + 9 * slot;
    mem[a]   = {1'b0, mask};
    mem[a+1] = dlo[7:0];
    mem[a+2] = dhi[7:0];
    mem[a+3] = {sc, ec};
    mem[a+4] = {dlo[8], so};
    mem[a+5] = {dhi[8], eo};
    mem[a+6] = {sp[11:8], ep[11:8]};
    mem[a+7] = sp[7:0];
    mem[a+8] = ep[7:0];
  endtask

  task automatic set_clock(input logic [3:0] s, input logic [6:0] m, input logic [8:0] d, input logic [6:0] w);
    now_slot_i = s; now_min_i = m; now_day_i = d; now_wday_i = w;
  endtask

  task automatic pulse_tick();
    @(posedge clk); #1 tick_i = 1'b1;
    @(posedge clk); #1 tick_i = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // {slot, min, day, wday, count, first ptr, second ptr}
  localparam logic [52:0] VEC [0:11] = '{
    {4'd4,  7'd0,   9'd10,  7'h02, 2'd2, 12'h01D, 12'h444},
    {4'd4,  7'd0,   9'd10,  7'h01, 2'd0, 12'h000, 12'h000},
    {4'd1,  7'd30,  9'd100, 7'h08, 2'd2, 12'hA11, 12'hB22},
    {4'd1,  7'd30,  9'd200, 7'h40, 2'd2, 12'hA11, 12'hB22},
    {4'd1,  7'd30,  9'd201, 7'h40, 2'd0, 12'h000, 12'h000},
    {4'd1,  7'd30,  9'd99,  7'h08, 2'd0, 12'h000, 12'h000},
    {4'd0,  7'd0,   9'd256, 7'h01, 2'd1, 12'h300, 12'h000},
    {4'd11, 7'd119, 9'd300, 7'h01, 2'd1, 12'h301, 12'h000},
    {4'd11, 7'd119, 9'd301, 7'h01, 2'd0, 12'h000, 12'h000},
    {4'd9,  7'd0,   9'd365, 7'h20, 2'd1, 12'h022, 12'h000},
    {4'd4,  7'd0,   9'd45,  7'h02, 2'd1, 12'h01D, 12'h000},
    {4'd4,  7'd1,   9'd10,  7'h02, 2'd0, 12'h000, 12'h000}
  };

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    put_entry(0, 7'h3E, 9'd0,   9'd365, 4'd4,  7'd0,  4'd9,  7'd0,   12'h01D, 12'h022);
    put_entry(1, 7'h7F, 9'd100, 9'd200, 4'd1,  7'd30, 4'd1,  7'd30,  12'hA11, 12'hB22);
    put_entry(2, 7'h01, 9'd256, 9'd300, 4'd0,  7'd0,  4'd11, 7'd119, 12'h300, 12'h301);
    put_entry(3, 7'h7F, 9'd50,  9'd40,  4'd4,  7'd0,  4'd4,  7'd0,   12'hDDD, 12'hEEE);
    put_entry(4, 7'h02, 9'd0,   9'd20,  4'd4,  7'd0,  4'd15, 7'd0,   12'h444, 12'h445);
    mem[2 + 9*5] = 8'hFF;
    put_entry(6, 7'h7F, 9'd0,   9'd511, 4'd4,  7'd0,  4'd0,  7'd0,   12'hFFF, 12'hFFE);

    wait_cycles(4);
    // R1
    chk(!ptr_valid_o, "R1 valid in reset", ptr_valid_o, 0);
    chk(!mem_rd_o, "R1 read in reset", mem_rd_o, 0);
    rst_n = 1'b1;
    wait_cycles(1);
    chk(!ptr_valid_o && !mem_rd_o, "R1 idle after reset", {ptr_valid_o, mem_rd_o}, 0);

    // R2 R3 R4 R5 R6 R7 R8 through the vector table
    for (int v = 0; v < 12; v++) begin
      set_clock(VEC[v][52:49], VEC[v][48:42], VEC[v][41:33], VEC[v][32:26]);
      ngot = 0;
      pulse_tick();
      wait_cycles(400);
      chk(ngot == int'(VEC[v][25:24]), $sformatf("R3/R4/R5 vector %0d count", v), ngot, VEC[v][25:24]);
      if (VEC[v][25:24] >= 2'd1 && ngot >= 1)
        chk(got[0] == VEC[v][23:12], $sformatf("R6/R7 vector %0d first", v), got[0], VEC[v][23:12]);
      if (VEC[v][25:24] == 2'd2 && ngot >= 2)
        chk(got[1] == VEC[v][11:0], $sformatf("R8 vector %0d second", v), got[1], VEC[v][11:0]);
    end

    // R9 back-pressure
    set_clock(4'd1, 7'd30, 9'd150, 7'h04);
    ngot = 0;
    ptr_ready_i = 1'b0;
    pulse_tick();
    wait_cycles(100);
    chk(ptr_valid_o && ptr_o == 12'hA11, "R9 offered under stall", ptr_o, 12'hA11);
    wait_cycles(30);
    chk(ptr_valid_o && ptr_o == 12'hA11, "R9 held under stall", ptr_o, 12'hA11);
    chk(ngot == 0, "R9 nothing taken", ngot, 0);
    ptr_ready_i = 1'b1;
    wait_cycles(400);
    chk(ngot == 2 && got[0] == 12'hA11 && got[1] == 12'hB22, "R9 after release", ngot, 2);

    // R10 extra tick during scan
    set_clock(4'd4, 7'd0, 9'd10, 7'h02);
    ngot = 0;
    pulse_tick();
    wait_cycles(3);
    pulse_tick();
    wait_cycles(500);
    chk(ngot == 2, "R10 single scan", ngot, 2);

    // R11 clock changes after the tick
    ngot = 0;
    pulse_tick();
    set_clock(4'd4, 7'd0, 9'd10, 7'h01);
    wait_cycles(400);
    chk(ngot == 2 && got[0] == 12'h01D && got[1] == 12'h444, "R11 snapshot", ngot, 2);

    // R12 no terminator: last entry that fits is at 245..253
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    put_entry(27, 7'h7F, 9'd0, 9'd511, 4'd4, 7'd0, 4'd15, 7'd0, 12'h5A5, 12'h000);
    set_clock(4'd4, 7'd0, 9'd10, 7'h02);
    ngot = 0;
    pulse_tick();
    wait_cycles(600);
    chk(ngot == 1 && got[0] == 12'h5A5, "R12 last entry", ngot, 1);
    chk(!mem_rd_o && !ptr_valid_o, "R12 back to idle", mem_rd_o, 0);
    ngot = 0;
    pulse_tick();
    wait_cycles(600);
    chk(ngot == 1, "R12 rescan after end", ngot, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule